// File: doc/BRIEF.md
# Floating-Point Add/Subtract Core (Unrounded)

This block adds or subtracts two floating-point operands held in an unpacked working format. Each operand has a class, a sign, a signed 16-bit exponent and a 64-bit fraction. A normalized fraction has its leading one at bit 61. Bit 62 is the carry position, and the bits below the leading one hold the fraction and its guard bits. The result comes back in the same format, normalized but not rounded, together with a 3-bit status vector. Rounding is left to a separate unit further down the datapath.

Operands enter on `in_valid`, and `op_sub` selects subtraction. Special classes are resolved by a fixed precedence. Finite operands are aligned to the larger exponent, and the bits shifted out are folded into a sticky LSB. The aligned values are summed in two's complement and the sum is renormalized. The datapath has two register stages: the special-case and alignment logic feeds stage one, and the sum and normalizer feed stage two. A new operation may enter every cycle.

Top module: `fpadd_top`

## Requirements
- R1: `out_valid` rises exactly two clock cycles after the `in_valid` that produced it, one result per accepted operation and in order. While reset is active, and until the first accepted operation has passed through, `out_valid` is 0.
- R2: Class codes are: 0 zero, 1 finite number, 2 quiet NaN, 3 signalling NaN, 4 infinity. NaN precedence is: signalling NaN on `a`, then signalling NaN on `b`, then quiet NaN on `a`, then quiet NaN on `b`. A signalling NaN is returned with its class changed to 2 (sign, exponent and fraction kept) and status bit 1 set. A quiet NaN is returned unchanged with status 0.
- R3: The effective sign of `b` is `b_sign` XOR `op_sub`. Two infinities whose signs differ (using `b`'s effective sign) give the default NaN (class 2, sign 0, exponent 0, fraction 0) with status bit 2. Any other case with an infinity returns the infinite operand, with `a` taking precedence and `b` carrying its effective sign, and status 0.
- R4: Two zeros give a zero (exponent 0, fraction 0) whose sign is `a_sign` AND the effective sign of `b`. When only one operand is zero, the result is the other operand, with `b` carrying its effective sign. Status is 0 in both cases.
- R5: For finite operands whose exponent difference in magnitude is 61 or more, the larger-exponent operand is returned unchanged (with `b` carrying its effective sign) and status bit 0 is set. A difference of 60 takes the aligned path.
- R6: The smaller operand's fraction is shifted right by the exponent difference. If any bit shifted out was 1, bit 0 of the shifted fraction is forced to 1 and status bit 0 is set. Otherwise status bit 0 stays clear.
- R7: An exact cancellation returns class 0, sign 0, exponent 0, fraction 0, with status 0.
- R8: A negative two's-complement sum returns sign 1 with the magnitude as the fraction.
- R9: A sum reaching bit 62 is shifted right by one, its old bit 0 is ORed into the new bit 0, and the exponent is incremented.
- R10: A sum below bit 61 is shifted left in a single pass until bit 61 is 1, and the exponent is lowered by the shift count.
- R11: Status bits: bit 0 inexact, bit 1 invalid from a signalling NaN, bit 2 invalid from infinity minus infinity. At most one invalid bit is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands present this cycle |
| op_sub | input | 1 | 1 = a minus b, 0 = a plus b |
| a_cls | input | 3 | Class of a |
| a_sign | input | 1 | Sign of a |
| a_exp | input | 16 | Signed exponent of a |
| a_frac | input | 64 | Fraction of a, leading one at bit 61 |
| b_cls | input | 3 | Class of b |
| b_sign | input | 1 | Sign of b |
| b_exp | input | 16 | Signed exponent of b |
| b_frac | input | 64 | Fraction of b, leading one at bit 61 |
| out_valid | output | 1 | Result present |
| r_cls | output | 3 | Result class |
| r_sign | output | 1 | Result sign |
| r_exp | output | 16 | Result signed exponent |
| r_frac | output | 64 | Result fraction, unrounded |
| r_status | output | 3 | Status flags |

## Verification
A fault in a stage-one register can show up in several ways at the ports. A wrong special-case select swaps in the wrong operand or the wrong status. A wrong alignment amount or a lost sticky bit shifts the fraction and the exponent in ways that can be seen. Either fault is visible on the very next `out_valid`, two cycles after the operation entered. A fault in the normalizer or the sign/negation stage shows as a fraction whose leading one is not at bit 61, a flipped sign, or an exponent off by the shift count, in the same cycle the result appears. A broken valid pipeline shows as a missing, extra or early result, which the scoreboard sees at once as a queue mismatch.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int FRAC_W    = 64;
  localparam int EXP_W     = 16;
  localparam int LEAD_BIT  = FRAC_W - 3;
  localparam int CARRY_BIT = FRAC_W - 2;
  localparam int FAR_GAP   = LEAD_BIT;
  localparam int ST_W      = 3;
  localparam int ST_INEXACT = 0;
  localparam int ST_SNAN    = 1;
  localparam int ST_ISI     = 2;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_QNAN = 3'd2,
    CLS_SNAN = 3'd3,
    CLS_INF  = 3'd4
  } fcls_e;

  typedef struct packed {
    fcls_e                    cls;
    logic                     sign;
    logic signed [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0]        frac;
  } fop_t;

  localparam fop_t DEF_QNAN = '{cls: CLS_QNAN, sign: 1'b0, exp: '0, frac: '0};
  localparam fop_t ZERO_OP  = '{cls: CLS_ZERO, sign: 1'b0, exp: '0, frac: '0};
endpackage

// File: rtl/fpadd_special.sv
module fpadd_special
  import fpadd_pkg::*;
(
  input  fop_t              a,
  input  fop_t              b,
  input  logic              op_sub,
  output logic              hit,
  output fop_t              res,
  output logic [ST_W-1:0]   st
);
  logic bs;
  fop_t b_eff;

  assign bs = b.sign ^ op_sub;

  always_comb begin
    b_eff      = b;
    b_eff.sign = bs;
  end

  // fixed precedence: NaNs, infinities, zeros, then finite path
  always_comb begin
    hit = 1'b1;
    res = a;
    st  = '0;
    if (a.cls == CLS_SNAN) begin
      res     = a;
      res.cls = CLS_QNAN;
      st[ST_SNAN] = 1'b1;
    end else if (b.cls == CLS_SNAN) begin
      res     = b;
      res.cls = CLS_QNAN;
      st[ST_SNAN] = 1'b1;
    end else if (a.cls == CLS_QNAN) begin
      res = a;
    end else if (b.cls == CLS_QNAN) begin
      res = b;
    end else if (a.cls == CLS_INF) begin
      if (b.cls == CLS_INF && a.sign != bs) begin
        res = DEF_QNAN;
        st[ST_ISI] = 1'b1;
      end else begin
        res = a;
      end
    end else if (b.cls == CLS_INF) begin
      res = b_eff;
    end else if (a.cls == CLS_ZERO) begin
      if (b.cls == CLS_ZERO) begin
        res      = ZERO_OP;
        res.sign = a.sign & bs;
      end else begin
        res = b_eff;
      end
    end else if (b.cls == CLS_ZERO) begin
      res = a;
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
(
  input  fop_t                     a,
  input  fop_t                     b_eff,
  output logic                     far,
  output fop_t                     far_res,
  output logic signed [EXP_W-1:0]  exp_big,
  output logic [FRAC_W-1:0]        frac_a,
  output logic [FRAC_W-1:0]        frac_b,
  output logic                     inexact
);
  localparam int AMT_W = $clog2(FAR_GAP);
  localparam logic signed [EXP_W:0] FAR_P = (EXP_W+1)'(FAR_GAP);

  logic signed [EXP_W:0] diff;
  logic                  a_small;
  logic [AMT_W-1:0]      amt;
  logic [FRAC_W-1:0]     small_f;
  logic [FRAC_W-1:0]     lost_mask;
  logic [FRAC_W-1:0]     shifted;
  logic                  lost;

  always_comb begin
    diff    = $signed({a.exp[EXP_W-1], a.exp}) - $signed({b_eff.exp[EXP_W-1], b_eff.exp});
    far     = (diff >= FAR_P) || (diff <= -FAR_P);
    far_res = (diff > 0) ? a : b_eff;
    a_small = diff < 0;
    amt     = AMT_W'(a_small ? -diff : diff);
    small_f = a_small ? a.frac : b_eff.frac;
    lost_mask = ~({FRAC_W{1'b1}} << amt);
    lost    = |(small_f & lost_mask);
    shifted = (small_f >> amt) | {{(FRAC_W-1){1'b0}}, lost};
    frac_a  = a_small ? shifted : a.frac;
    frac_b  = a_small ? b_eff.frac : shifted;
    exp_big = a_small ? b_eff.exp : a.exp;
    inexact = far | lost;
  end
endmodule

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
  parameter int W  = 62,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] msb_pos
);
  always_comb begin
    msb_pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) msb_pos = PW'(i);
    end
  end
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
(
  input  logic signed [FRAC_W-1:0] sum,
  input  logic signed [EXP_W-1:0]  exp_in,
  output fop_t                     res,
  output logic                     is_zero
);
  localparam int LW = LEAD_BIT + 1;
  localparam int PW = $clog2(LW);
  localparam logic signed [EXP_W-1:0] E_ONE = EXP_W'(1);

  logic [FRAC_W-1:0]        mag;
  logic [PW-1:0]            msb_pos;
  logic [PW-1:0]            lz;
  logic signed [EXP_W-1:0]  lz_s;

  assign mag = sum[FRAC_W-1] ? FRAC_W'(-sum) : FRAC_W'(sum);

  fpadd_lzc #(.W(LW), .PW(PW)) u_lzc (
    .vec     (mag[LEAD_BIT:0]),
    .msb_pos (msb_pos)
  );

  assign lz   = PW'(LEAD_BIT) - msb_pos;
  assign lz_s = $signed({{(EXP_W-PW){1'b0}}, lz});

  always_comb begin
    is_zero  = (mag == '0);
    res.cls  = CLS_NUM;
    res.sign = sum[FRAC_W-1];
    res.exp  = exp_in;
    res.frac = mag;
    if (is_zero) begin
      res = ZERO_OP;
    end else if (mag[CARRY_BIT]) begin
      res.frac = (mag >> 1) | {{(FRAC_W-1){1'b0}}, mag[0]};
      res.exp  = exp_in + E_ONE;
    end else begin
      res.frac = mag << lz;
      res.exp  = exp_in - lz_s;
    end
  end
endmodule

// File: rtl/fpadd_top.sv
module fpadd_top
  import fpadd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 op_sub,
  input  logic [2:0]           a_cls,
  input  logic                 a_sign,
  input  logic [EXP_W-1:0]     a_exp,
  input  logic [FRAC_W-1:0]    a_frac,
  input  logic [2:0]           b_cls,
  input  logic                 b_sign,
  input  logic [EXP_W-1:0]     b_exp,
  input  logic [FRAC_W-1:0]    b_frac,
  output logic                 out_valid,
  output logic [2:0]           r_cls,
  output logic                 r_sign,
  output logic [EXP_W-1:0]     r_exp,
  output logic [FRAC_W-1:0]    r_frac,
  output logic [ST_W-1:0]      r_status
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ln = rst_pipe[1];

  fop_t a_op, b_op, b_eff;

  always_comb begin
    a_op  = '{cls: fcls_e'(a_cls), sign: a_sign, exp: $signed(a_exp), frac: a_frac};
    b_op  = '{cls: fcls_e'(b_cls), sign: b_sign, exp: $signed(b_exp), frac: b_frac};
    b_eff = b_op;
    b_eff.sign = b_sign ^ op_sub;
  end

  // stage 1 combinational
  logic              sp_hit;
  fop_t              sp_res;
  logic [ST_W-1:0]   sp_st;
  logic              al_far;
  fop_t              al_far_res;
  logic signed [EXP_W-1:0] al_exp;
  logic [FRAC_W-1:0] al_fa, al_fb;
  logic              al_inexact;

  fpadd_special u_special (
    .a      (a_op),
    .b      (b_op),
    .op_sub (op_sub),
    .hit    (sp_hit),
    .res    (sp_res),
    .st     (sp_st)
  );

  fpadd_align u_align (
    .a       (a_op),
    .b_eff   (b_eff),
    .far     (al_far),
    .far_res (al_far_res),
    .exp_big (al_exp),
    .frac_a  (al_fa),
    .frac_b  (al_fb),
    .inexact (al_inexact)
  );

  logic            s1_bypass_d;
  fop_t            s1_res_d;
  logic [ST_W-1:0] s1_st_d;

  always_comb begin
    s1_bypass_d = sp_hit | al_far;
    s1_res_d    = sp_hit ? sp_res : al_far_res;
    s1_st_d     = '0;
    if (sp_hit) s1_st_d = sp_st;
    else        s1_st_d[ST_INEXACT] = al_inexact;
  end

  // stage 1 registers
  logic                     s1_valid;
  logic                     s1_bypass;
  fop_t                     s1_res;
  logic [ST_W-1:0]          s1_st;
  logic                     s1_sa, s1_sb;
  logic signed [EXP_W-1:0]  s1_exp;
  logic [FRAC_W-1:0]        s1_fa, s1_fb;

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) s1_valid <= 1'b0;
    else         s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_bypass <= s1_bypass_d;
      s1_res    <= s1_res_d;
      s1_st     <= s1_st_d;
      s1_sa     <= a_sign;
      s1_sb     <= b_eff.sign;
      s1_exp    <= al_exp;
      s1_fa     <= al_fa;
      s1_fb     <= al_fb;
    end
  end

  // stage 2 combinational: two's complement sum and renormalization
  logic signed [FRAC_W-1:0] va, vb, sum;
  fop_t                     nm_res;
  logic                     nm_zero;
  fop_t                     out_d;
  logic [ST_W-1:0]          st_d;

  always_comb begin
    va  = s1_sa ? -$signed(s1_fa) : $signed(s1_fa);
    vb  = s1_sb ? -$signed(s1_fb) : $signed(s1_fb);
    sum = va + vb;
  end

  fpadd_norm u_norm (
    .sum     (sum),
    .exp_in  (s1_exp),
    .res     (nm_res),
    .is_zero (nm_zero)
  );

  always_comb begin
    out_d = s1_bypass ? s1_res : nm_res;
    st_d  = (!s1_bypass && nm_zero) ? '0 : s1_st;
  end

  // stage 2 registers
  fop_t            out_q;
  logic [ST_W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) out_valid <= 1'b0;
    else         out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      out_q <= out_d;
      st_q  <= st_d;
    end
  end

  assign r_cls    = out_q.cls;
  assign r_sign   = out_q.sign;
  assign r_exp    = out_q.exp;
  assign r_frac   = out_q.frac;
  assign r_status = st_q;
endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk
  import fpadd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [2:0]        r_cls,
  input logic              r_sign,
  input logic [FRAC_W-1:0] r_frac,
  input logic [ST_W-1:0]   r_status
);
  logic [1:0] vpipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vpipe <= '0;
    else        vpipe <= {vpipe[0], in_valid};
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vpipe[1]);

  p_snan_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_status[ST_SNAN]) |-> (r_cls == 3'(CLS_QNAN)));

  p_isi_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_status[ST_ISI]) |-> (r_cls == 3'(CLS_QNAN) && !r_sign && r_frac == '0));

  p_zero_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_cls == 3'(CLS_ZERO)) |-> (r_frac == '0 && r_status == '0));

  p_lead_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_cls == 3'(CLS_NUM)) |-> (r_frac[CARRY_BIT:LEAD_BIT] == 2'b01));

  p_one_invalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(r_status[ST_SNAN] && r_status[ST_ISI]));
endmodule

bind fpadd_top fpadd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_ln),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .r_cls     (r_cls),
  .r_sign    (r_sign),
  .r_frac    (r_frac),
  .r_status  (r_status)
);

// File: tb/fpadd_top_tb.sv
module fpadd_top_tb;
  import fpadd_pkg::*;

  localparam logic [63:0] ONE = 64'h2000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, op_sub;
  logic [2:0] a_cls, b_cls;
  logic a_sign, b_sign;
  logic [15:0] a_exp, b_exp;
  logic [63:0] a_frac, b_frac;
  logic out_valid;
  logic [2:0] r_cls;
  logic r_sign;
  logic [15:0] r_exp;
  logic [63:0] r_frac;
  logic [2:0] r_status;

  int total = 0;
  int bad = 0;
  bit done = 0;

  fop_t            q_res[$];
  logic [2:0]      q_st[$];
  string           q_tag[$];

  always #2 clk = ~clk;

  fpadd_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .a_cls(a_cls), .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
    .b_cls(b_cls), .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
    .out_valid(out_valid), .r_cls(r_cls), .r_sign(r_sign), .r_exp(r_exp),
    .r_frac(r_frac), .r_status(r_status)
  );

  function automatic fop_t mk(fcls_e c, logic s, int e, logic [63:0] f);
    fop_t o;
    o.cls = c; o.sign = s; o.exp = 16'(e); o.frac = f;
    return o;
  endfunction

  // expected result from the requirements
  function automatic void model(input logic sub, input fop_t a, input fop_t b,
                                output fop_t r, output logic [2:0] st);
    logic bs;
    fop_t be;
    int d, e;
    logic [63:0] fa, fb, m;
    longint va, vb, s;
    logic lost;
    bs = b.sign ^ sub;
    be = b; be.sign = bs;
    st = 3'b000;
    r = a;
    if (a.cls == CLS_SNAN) begin r = a; r.cls = CLS_QNAN; st = 3'b010; end
    else if (b.cls == CLS_SNAN) begin r = b; r.cls = CLS_QNAN; st = 3'b010; end
    else if (a.cls == CLS_QNAN) r = a;
    else if (b.cls == CLS_QNAN) r = b;
    else if (a.cls == CLS_INF) begin
      if (b.cls == CLS_INF && a.sign != bs) begin r = mk(CLS_QNAN, 0, 0, 0); st = 3'b100; end
      else r = a;
    end
    else if (b.cls == CLS_INF) r = be;
    else if (a.cls == CLS_ZERO) begin
      if (b.cls == CLS_ZERO) r = mk(CLS_ZERO, a.sign & bs, 0, 0);
      else r = be;
    end
    else if (b.cls == CLS_ZERO) r = a;
    else begin
      d = int'(a.exp) - int'(b.exp);
      if (d >= 61) begin r = a; st = 3'b001; end
      else if (d <= -61) begin r = be; st = 3'b001; end
      else begin
        fa = a.frac; fb = b.frac;
        if (d >= 0) begin
          e = int'(a.exp);
          lost = (fb & ((64'd1 << d) - 64'd1)) != 0;
          fb = fb >> d;
          if (lost) fb[0] = 1'b1;
        end else begin
          e = int'(b.exp);
          lost = (fa & ((64'd1 << (-d)) - 64'd1)) != 0;
          fa = fa >> (-d);
          if (lost) fa[0] = 1'b1;
        end
        va = a.sign ? -longint'(fa) : longint'(fa);
        vb = bs ? -longint'(fb) : longint'(fb);
        s = va + vb;
        if (s == 0) begin
          r = mk(CLS_ZERO, 0, 0, 0);
        end else begin
          m = (s < 0) ? 64'(-s) : 64'(s);
          if (m[62]) begin
            m = (m >> 1) | {63'd0, m[0]};
            e = e + 1;
          end else begin
            while (!m[61]) begin m = m << 1; e = e - 1; end
          end
          r = mk(CLS_NUM, s < 0, e, m);
          st = {2'b00, lost};
        end
      end
    end
  endfunction

  task automatic send(string tag, logic sub, fop_t a, fop_t b);
    fop_t r;
    logic [2:0] st;
    @(negedge clk);
    in_valid = 1'b1; op_sub = sub;
    a_cls = a.cls; a_sign = a.sign; a_exp = a.exp; a_frac = a.frac;
    b_cls = b.cls; b_sign = b.sign; b_exp = b.exp; b_frac = b.frac;
    model(sub, a, b, r, st);
    q_res.push_back(r); q_st.push_back(st); q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      total++;
      if (q_res.size() == 0) begin
        bad++;
        $display("FAIL R1: unexpected result, got valid=1 expected none");
      end else begin
        fop_t e;
        logic [2:0] es;
        string t;
        e = q_res.pop_front(); es = q_st.pop_front(); t = q_tag.pop_front();
        if (r_cls != e.cls || r_sign != e.sign || r_exp != e.exp ||
            r_frac != e.frac || r_status != es) begin
          bad++;
          $display("FAIL %s: got cls=%0d s=%0d e=%0d f=%h st=%b expected cls=%0d s=%0d e=%0d f=%h st=%b",
                   t, r_cls, r_sign, $signed(r_exp), r_frac, r_status,
                   e.cls, e.sign, e.exp, e.frac, es);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1: watchdog expired, got hang expected completion");
    summary();
  end

  initial begin
    fop_t qa, qb, sa, sb;
    rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0;
    a_cls = 0; a_sign = 0; a_exp = 0; a_frac = 0;
    b_cls = 0; b_sign = 0; b_exp = 0; b_frac = 0;
    repeat (4) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++; $display("FAIL R1: reset out_valid got %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    idle(4);

    qa = mk(CLS_QNAN, 1, 7, 64'h5);
    qb = mk(CLS_QNAN, 0, 3, 64'h9);
    sa = mk(CLS_SNAN, 0, 2, 64'h11);
    sb = mk(CLS_SNAN, 1, 4, 64'h22);
    // R2 NaN precedence
    send("R2", 0, sa, sb);
    send("R2", 0, qa, sb);
    send("R2", 1, qa, qb);
    send("R2", 0, mk(CLS_INF, 0, 0, 0), qb);
    // R3 infinities
    send("R3", 0, mk(CLS_INF, 0, 0, 0), mk(CLS_INF, 1, 0, 0));
    send("R3", 1, mk(CLS_INF, 1, 0, 0), mk(CLS_INF, 1, 0, 0));
    send("R3", 1, mk(CLS_INF, 0, 0, 0), mk(CLS_INF, 1, 0, 0));
    send("R3", 1, mk(CLS_NUM, 0, 3, ONE), mk(CLS_INF, 0, 0, 0));
    // R4 zeros
    send("R4", 0, mk(CLS_ZERO, 1, 0, 0), mk(CLS_ZERO, 1, 0, 0));
    send("R4", 1, mk(CLS_ZERO, 1, 0, 0), mk(CLS_ZERO, 1, 0, 0));
    send("R4", 1, mk(CLS_ZERO, 0, 0, 0), mk(CLS_NUM, 0, 5, ONE | 64'h40));
    send("R4", 1, mk(CLS_NUM, 1, -5, ONE), mk(CLS_ZERO, 0, 0, 0));
    // R5 far exponents and boundary
    send("R5", 0, mk(CLS_NUM, 0, 61, ONE), mk(CLS_NUM, 0, 0, ONE | 64'h3));
    send("R5", 1, mk(CLS_NUM, 0, 0, ONE), mk(CLS_NUM, 0, 61, ONE));
    send("R5", 0, mk(CLS_NUM, 0, 60, ONE), mk(CLS_NUM, 0, 0, ONE));
    // R6 sticky alignment
    send("R6", 0, mk(CLS_NUM, 0, 3, ONE), mk(CLS_NUM, 0, 0, ONE | 64'h1));
    send("R6", 0, mk(CLS_NUM, 0, 0, ONE | 64'h4), mk(CLS_NUM, 0, 2, ONE));
    // R7 cancellation
    send("R7", 1, mk(CLS_NUM, 1, 9, ONE | 64'h77), mk(CLS_NUM, 1, 9, ONE | 64'h77));
    // R8 negative sum
    send("R8", 1, mk(CLS_NUM, 0, 0, ONE), mk(CLS_NUM, 0, 1, ONE));
    // R9 carry with sticky
    send("R9", 0, mk(CLS_NUM, 0, 0, ONE | 64'h1), mk(CLS_NUM, 0, 0, ONE));
    // R10 large left shift
    send("R10", 1, mk(CLS_NUM, 0, 0, ONE + 64'd5), mk(CLS_NUM, 0, 0, ONE));
    idle(3);

    // R11 mixed random traffic with bubbles
    for (int i = 0; i < 400; i++) begin
      fop_t ra, rb;
      logic [63:0] fr;
      fr = {$urandom, $urandom};
      if (i % 3 == 0) fr[20:0] = '0;
      ra = mk(CLS_NUM, 1'($urandom), int'($urandom_range(0, 140)) - 70, ONE | (fr & (ONE - 64'd1)));
      fr = {$urandom, $urandom};
      rb = mk(CLS_NUM, 1'($urandom), int'($urandom_range(0, 140)) - 70, ONE | (fr & (ONE - 64'd1)));
      if (i % 5 == 0) rb.exp = ra.exp;
      if (i % 11 == 0) rb.cls = fcls_e'(3'($urandom_range(0, 4)));
      send("R11", 1'($urandom), ra, rb);
      if (i % 7 == 0) idle(1);
    end
    idle(6);
    total++;
    if (q_res.size() != 0) begin
      bad++; $display("FAIL R1: pending results got %0d expected 0", q_res.size());
    end
    summary();
  end
endmodule